// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Controller

This block sits between a synchronous host and a 2K x 8 asynchronous static RAM. It accepts one read or write request at a time and turns it into the chip-enable, output-enable and write-enable strobes, the address, and the data-bus drive that the memory needs. It enforces every setup time, pulse width, hold time and cycle spacing by counting clock cycles. Each phase length is derived from a timing figure in nanoseconds, divided by the clock period and rounded up to the next whole cycle.

The host raises `req_valid` with `req_write`, `req_addr` and `req_wdata`. The request is taken on the clock edge where `req_ready` is also high. Completion is marked by a single-cycle `rsp_done`, and for a read the byte is on `rsp_rdata` in that same cycle. After reset the controller holds every strobe inactive for a power-up settling interval before it accepts the first request. Output enable is never asserted during a write, so the memory and the controller never drive the data bus at the same time.

The controller is a single state machine. Its states are:

| State | What it does |
|---|---|
| ST_PWRUP | Settling after reset |
| ST_IDLE | Ready for a request |
| ST_RD_ACC | Read access window |
| ST_RD_SMP | Read sample cycle |
| ST_WR_PULSE | Write-enable pulse |
| ST_WR_HOLD | Data hold after the write |
| ST_RECOVER | Cycle-time recovery |

Its transitions are:

- ST_PWRUP goes to ST_IDLE when the settling count finishes.
- ST_IDLE goes to ST_RD_ACC or ST_WR_PULSE when a request is accepted.
- ST_RD_ACC goes to ST_RD_SMP when the access timer expires.
- ST_RD_SMP goes to ST_RECOVER unconditionally.
- ST_WR_PULSE goes to ST_WR_HOLD when the pulse timer expires.
- ST_WR_HOLD goes to ST_RECOVER when the hold timer expires.
- ST_RECOVER goes to ST_IDLE when the recovery timer expires.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted, `sram_e_n`, `sram_g_n` and `sram_w_n` are 1, and `sram_dq_oe`, `req_ready` and `rsp_done` are 0.
- R2: After reset is released, `req_ready` stays 0 and `sram_e_n` and `sram_w_n` stay 1 for at least PWRUP_CYC clock cycles.
- R3: A read holds `sram_e_n` and `sram_g_n` low together, with `sram_w_n` high, for exactly RD_ACC+1 cycles. RD_ACC is the larger of the address access time and the output-enable access time, each rounded up to whole cycles; with the defaults this gives 8 cycles.
- R4: Read data is sampled at the end of the last low-strobe cycle, which comes after the full access window. It appears on `rsp_rdata` in the one cycle where `rsp_done` is 1.
- R5: A write holds `sram_e_n` and `sram_w_n` low for WP cycles, with `sram_g_n` high throughout. WP is the largest of the write pulse width, the address-to-end-of-write time and the data setup time, each in whole cycles; with the defaults this gives 6 cycles.
- R6: `sram_dq_oe` is 1 from the cycle where `sram_w_n` falls through DH cycles after it rises, with the write byte unchanged during that time. DH is at least one cycle. `sram_dq_oe` is never 1 while `sram_g_n` is 0.
- R7: `sram_addr` does not change while `sram_e_n` is low or during the write hold.
- R8: Successive falling edges of `sram_e_n` are at least RC cycles apart, where RC is the cycle time in whole cycles (7 with the defaults). `req_ready` is 1 only when all strobes are inactive. `rsp_done` never lasts more than one cycle.
- R9: A request raised while `req_ready` is 0 and withdrawn before `req_ready` returns to 1 has no effect on the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 100 MHz |
| rst_n | input | 1 | Active-low asynchronous reset; releasing it marks power as valid |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller can take a request this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte read, valid with rsp_done |
| sram_addr | output | ADDR_W | Address to the memory |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enables the data-bus driver |
| sram_dq_in | input | DATA_W | Data returned by the memory |
| sram_e_n | output | 1 | Chip enable, active low |
| sram_g_n | output | 1 | Output enable, active low |
| sram_w_n | output | 1 | Write enable, active low |

## Verification
The bench keeps the default nanosecond timing figures and the 10 ns clock, so the read window is 8 cycles, the write pulse is 6 cycles, the data hold is 1 cycle and the cycle time is 7 cycles. It lowers PWRUP_CYC from the 2 ms default to 20 cycles. This lets the settling interval finish early, and the bench can still check that no strobe or ready signal appears before it ends. The memory model in the bench returns a poison byte until the enable strobes have been low for the full access window. That makes early sampling, a short write pulse and a missing hold cycle visible at the ports.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_RD_ACC   = 3'd2,
        ST_RD_SMP   = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5,
        ST_RECOVER  = 3'd6
    } ctl_state_e;

    // Round a nanosecond figure up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Loadable down-counter that times each bus phase.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_pwrup_guard.sv
// Counts the settling interval after reset release.
module sram_pwrup_guard #(
    parameter int LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic settled
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 70,     // minimum cycle time
    parameter int T_AA_NS   = 70,     // address / enable to data
    parameter int T_OE_NS   = 35,     // output enable to data
    parameter int T_WP_NS   = 50,     // write pulse width
    parameter int T_AW_NS   = 60,     // address valid to end of write
    parameter int T_DS_NS   = 30,     // data setup to end of write
    parameter int T_DH_NS   = 5,      // data hold after end of write
    parameter int GAP_CYC   = 1,      // minimum strobe-high gap
    parameter int PWRUP_CYC = 200000  // settling after power valid
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_e_n,
    output logic              sram_g_n,
    output logic              sram_w_n
);
    localparam int RD_ACC = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int WP     = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_DS_NS, CLK_NS), 1));
    localparam int DH     = imax(ns_to_cyc(T_DH_NS, CLK_NS), 1);
    localparam int RC     = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int RD_ACT = RD_ACC + 1;
    localparam int WR_ACT = WP + DH;
    localparam int RD_REC = imax(GAP_CYC, RC - RD_ACT);
    localparam int WR_REC = imax(GAP_CYC, RC - WR_ACT);
    localparam int T_MAX  = imax(imax(RD_ACC, WP), imax(imax(DH, RD_REC), WR_REC));
    localparam int TMR_W  = $clog2(T_MAX + 1);

    ctl_state_e state_q, state_d;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             settled;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    sram_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_pwrup_guard #(.LIMIT(PWRUP_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .settled (settled)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    // Next state and phase timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PWRUP: begin
                if (settled) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_PULSE;
                        tmr_val = TMR_W'(WP - 1);
                    end else begin
                        state_d = ST_RD_ACC;
                        tmr_val = TMR_W'(RD_ACC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) state_d = ST_RD_SMP;
            end
            ST_RD_SMP: begin
                state_d  = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(RD_REC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(DH - 1);
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(WR_REC - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_PWRUP;
        endcase
    end

    // Strobe outputs decoded from the state
    always_comb begin
        sram_e_n   = 1'b1;
        sram_g_n   = 1'b1;
        sram_w_n   = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_RD_ACC, ST_RD_SMP: begin
                sram_e_n = 1'b0;
                sram_g_n = 1'b0;
            end
            ST_WR_PULSE: begin
                sram_e_n   = 1'b0;
                sram_w_n   = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                sram_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    // Request capture and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_RD_SMP) rdata_q <= sram_dq_in;
            done_q <= (state_q == ST_RD_SMP) || (state_q == ST_WR_HOLD && tmr_expired);
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_done    = done_q;
    assign rsp_rdata   = rdata_q;
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W    = 11,
    parameter int PWRUP_CYC = 200000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              sram_e_n,
    input logic              sram_g_n,
    input logic              sram_w_n,
    input logic              sram_dq_oe,
    input logic [ADDR_W-1:0] sram_addr
);
    logic [31:0] up_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          up_cnt <= '0;
        else if (up_cnt < 32'(PWRUP_CYC))    up_cnt <= up_cnt + 1'b1;
    end

    p_ready_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> up_cnt >= 32'(PWRUP_CYC));

    p_enable_after_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_e_n |-> up_cnt >= 32'(PWRUP_CYC));

    p_write_g_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_w_n |-> (sram_g_n && !sram_e_n));

    p_write_drives_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_w_n |-> sram_dq_oe);

    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_g_n);

    p_hold_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_w_n) |-> sram_dq_oe);

    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_e_n || sram_dq_oe) && $past(!sram_e_n) |-> $stable(sram_addr));

    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_e_n && sram_w_n && sram_g_n && !sram_dq_oe));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .PWRUP_CYC (PWRUP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .sram_e_n   (sram_e_n),
    .sram_g_n   (sram_g_n),
    .sram_w_n   (sram_w_n),
    .sram_dq_oe (sram_dq_oe),
    .sram_addr  (sram_addr)
);

// File: tb/sram_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_bench;
    localparam int AW      = 11;
    localparam int DW      = 8;
    localparam int PWRUP   = 20;
    // Expected cycle counts at a 10 ns clock, worked out from the ns figures
    localparam int EXP_RD  = 8;   // 70 ns access -> 7 cycles, plus sample cycle
    localparam int EXP_ACC = 7;
    localparam int EXP_WP  = 6;   // max(50, 60, 30) ns -> 6 cycles
    localparam int EXP_RC  = 7;
    localparam logic [DW-1:0] POISON = 8'hEE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata, sram_dq_out, sram_dq_in;
    logic [AW-1:0] sram_addr;
    logic          sram_dq_oe, sram_e_n, sram_g_n, sram_w_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sram_strobe_ctrl #(.PWRUP_CYC(PWRUP)) u_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in),
        .sram_e_n(sram_e_n), .sram_g_n(sram_g_n), .sram_w_n(sram_w_n)
    );

    // ---------------- memory model ----------------
    function automatic logic [DW-1:0] init_val(input int a);
        return 8'((a * 7 + 1) & 255);
    endfunction

    logic [DW-1:0] mem [0:(1<<AW)-1];
    int rd_cnt = 0, last_rd = 0;
    int w_cnt = 0, last_wp = 0, hold_ok = 0, g_bad = 0, contend = 0, addr_chg = 0;
    int last_fall = 0, min_gap = 1000, have_fall = 0;
    logic prev_e_n = 1'b1;
    logic [AW-1:0] w_addr, prev_addr;
    logic [DW-1:0] w_data;

    initial for (int i = 0; i < (1<<AW); i++) mem[i] = init_val(i);

    assign sram_dq_in = (!sram_e_n && !sram_g_n && rd_cnt >= EXP_ACC) ? mem[sram_addr] : POISON;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (!sram_e_n && !sram_g_n) rd_cnt <= rd_cnt + 1;
            else begin
                if (rd_cnt > 0) last_rd <= rd_cnt;
                rd_cnt <= 0;
            end
            if (sram_dq_oe && !sram_g_n) contend <= contend + 1;
            if (!sram_e_n && !prev_e_n && sram_addr != prev_addr) addr_chg <= addr_chg + 1;
            if (!sram_w_n) begin
                w_cnt  <= w_cnt + 1;
                w_addr <= sram_addr;
                w_data <= sram_dq_out;
                if (!sram_g_n) g_bad <= g_bad + 1;
            end else if (w_cnt > 0) begin
                last_wp <= w_cnt;
                if (sram_dq_oe && sram_dq_out == w_data && sram_addr == w_addr)
                    hold_ok <= hold_ok + 1;
                mem[w_addr] <= w_data;
                w_cnt <= 0;
            end
            if (!sram_e_n && prev_e_n) begin
                if (have_fall != 0 && cyc - last_fall < min_gap) min_gap <= cyc - last_fall;
                last_fall <= cyc;
                have_fall <= 1;
            end
            prev_e_n  <= sram_e_n;
            prev_addr <= sram_addr;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired (R8 progress) actual=%0d expected<=20000", cyc);
        summary_and_end();
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [DW-1:0] rd);
        int t = 0;
        while (!rsp_done && t < 100) begin @(negedge clk); t++; end
        rd = rsp_rdata;
        chk("R4 done seen", rsp_done, int'(rsp_done), 1);
        @(negedge clk);
        chk("R8 done single cycle", !rsp_done, int'(rsp_done), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        @(negedge clk);
        chk("R1 e_n", sram_e_n, int'(sram_e_n), 1);
        chk("R1 g_n", sram_g_n, int'(sram_g_n), 1);
        chk("R1 w_n", sram_w_n, int'(sram_w_n), 1);
        chk("R1 dq_oe", !sram_dq_oe, int'(sram_dq_oe), 0);
        chk("R1 ready", !req_ready, int'(req_ready), 0);
        chk("R1 done", !rsp_done, int'(rsp_done), 0);
    endtask

    task automatic t_powerup();
        int quiet = 0;
        bit strobe_seen = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h010; req_wdata = 8'h42;
        rst_n = 1'b1;
        while (!req_ready && quiet < 1000) begin
            @(negedge clk);
            if (!sram_e_n || !sram_w_n) strobe_seen = 1;
            if (!req_ready) quiet++;
        end
        req_valid = 1'b0;
        chk("R2 settle cycles", quiet >= PWRUP, quiet, PWRUP);
        chk("R2 no strobe while settling", !strobe_seen, int'(strobe_seen), 0);
        @(negedge clk);
        chk("R2 no stray access", sram_e_n, int'(sram_e_n), 1);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] dummy;
        int h0 = hold_ok;
        issue(1'b1, a, d);
        wait_done(dummy);
        chk("R5 write pulse width", last_wp == EXP_WP, last_wp, EXP_WP);
        chk("R5 g_n high in write", g_bad == 0, g_bad, 0);
        chk("R6 data held after write", hold_ok == h0 + 1, hold_ok - h0, 1);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] got;
        issue(1'b0, a, 8'h00);
        wait_done(got);
        chk("R4 read data", got == exp, int'(got), int'(exp));
        chk("R3 read strobe length", last_rd == EXP_RD, last_rd, EXP_RD);
    endtask

    task automatic t_spacing();
        min_gap = 1000;
        have_fall = 0;
        t_write(11'h0A0, 8'h5B);
        t_read(11'h0A0, 8'h5B);
        t_read(11'h0A1, init_val(11'h0A1));
        chk("R8 enable spacing", min_gap >= EXP_RC, min_gap, EXP_RC);
    endtask

    task automatic t_ignore_busy();
        logic [DW-1:0] dummy;
        issue(1'b1, 11'h155, 8'h66);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'd100; req_wdata = 8'h99;
        @(negedge clk);
        chk("R9 ready low while busy", !req_ready, int'(req_ready), 0);
        req_valid = 1'b0;
        wait_done(dummy);
        t_read(11'd100, init_val(100));
        t_read(11'h155, 8'h66);
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_write(11'h000, 8'h11);
        t_read(11'h000, 8'h11);
        t_write(11'h7FF, 8'hC3);
        t_read(11'h7FF, 8'hC3);
        t_read(11'h2AA, init_val(11'h2AA));
        t_spacing();
        t_ignore_busy();
        chk("R6 no bus contention", contend == 0, contend, 0);
        chk("R7 address stable during access", addr_chg == 0, addr_chg, 0);
        summary_and_end();
    end
endmodule